// File: doc/BRIEF.md
# Maskable Burst Address Generator

This block produces the address for one port of a synchronous multi-port memory. On every clock it either passes the external address bus through or substitutes an internally held burst counter. The counter can be cleared, loaded from the bus or stepped forward, with a fixed priority among those operations. A mask register selects which low-order counter bits take part in counting. Bits outside the mask hold their value, and the masked field rolls over to zero after it reaches its all-ones value. This sets both where a burst wraps and how long it lasts.

The counter and the mask can each be read back. A readback request registers a snapshot, and the snapshot appears on a dedicated readback output one cycle later. A small state machine tracks this. Its state `RB_IDLE` means no readback is shown. `RB_COUNT` shows the captured counter and `RB_MASK` shows the captured mask. Every clock edge picks the next state from the strobes sampled on that edge: a legal counter readback request goes to `RB_COUNT`, otherwise a legal mask readback request goes to `RB_MASK`, otherwise the machine goes to `RB_IDLE`. These moves can be made from any state.

A registered terminal-count flag is raised when an increment leaves every masked bit set.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low the counter is zero, the mask is all ones, `term_irq` is 0 and `rd_oe` is 0. All of these hold on the first cycle after release.
- R2: When `cnt_rst_n`, `cnt_ld_n` and `cnt_inc_n` are all high, `eff_addr` equals `addr_in` in the same cycle, with no register in the path.
- R3: With `cnt_ld_n` low and `cnt_rst_n` high, `eff_addr` equals `addr_in` in that cycle, and the counter holds that value after the edge.
- R4: With `cnt_inc_n` low and the other counter strobes high, `eff_addr` shows the current counter, and the counter advances by one at the edge.
- R5: With `cnt_rst_n` low, `eff_addr` is 0 in that same cycle, so there is no dead cycle, and the counter is 0 after the edge. This takes precedence over load and increment.
- R6: When `cnt_ld_n` and `cnt_inc_n` are both low, the load wins and the counter takes `addr_in` without advancing.
- R7: An increment changes only the bits that are set in the mask. That field wraps from all ones to zero, and the unmasked bits keep their value. With the mask all ones, 0x7FFF steps to 0.
- R8: With `msk_ld_n` low and `cnt_ld_n` high, the mask takes `addr_in` at the edge. If `cnt_ld_n` is also low, the mask write is ignored.
- R9: `cnt_rd_n` low, with `cnt_ld_n`, `cnt_inc_n` and `cnt_rst_n` all high, makes `rd_oe` equal 1 and `rd_data` equal the counter value at that edge, during the next cycle. If any of those three is low, the request is ignored and `rd_oe` is 0.
- R10: `msk_rd_n` low, with `cnt_rd_n` and `msk_ld_n` high, makes `rd_oe` equal 1 and `rd_data` equal the mask during the next cycle.
- R11: `term_irq` is set at an edge whose increment leaves all masked counter bits at one. It is cleared by a load, a counter reset or an increment to a non-terminal value, and it holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge |
| rst_n | input | 1 | Master reset, active low, asynchronous assert |
| cnt_rst_n | input | 1 | Counter clear strobe, active low |
| cnt_ld_n | input | 1 | Counter load strobe, active low |
| cnt_inc_n | input | 1 | Counter increment strobe, active low |
| cnt_rd_n | input | 1 | Counter readback request, active low |
| msk_ld_n | input | 1 | Mask load strobe, active low |
| msk_rd_n | input | 1 | Mask readback request, active low |
| addr_in | input | AW | External address bus |
| eff_addr | output | AW | Address presented to the array |
| rd_data | output | AW | Readback value |
| rd_oe | output | 1 | Readback value valid |
| term_irq | output | 1 | Terminal-count flag |

## Verification
The hardest case to reach is a masked wrap in which the unmasked upper bits are non-zero. It needs three steps in order: a narrow mask must be written, the counter loaded with an odd upper part, and then several increments issued. The directed sequence writes mask 0x0003 and loads 0x1232. It then steps through terminal count and watches `eff_addr` fall back to 0x1230 while `term_irq` rises and then falls. Ignored writes and ignored readbacks are checked through the mask readback path and through `rd_oe`.

// File: rtl/bac_pkg.sv
package bac_pkg;
    typedef enum logic [1:0] {
        OP_HOLD,
        OP_INC,
        OP_LOAD,
        OP_CLR
    } cnt_op_e;

    typedef enum logic [1:0] {
        RB_IDLE,
        RB_COUNT,
        RB_MASK
    } rb_state_e;
endpackage

// File: rtl/bac_cmd_decode.sv
module bac_cmd_decode
    import bac_pkg::*;
(
    input  logic    cnt_rst_n,
    input  logic    cnt_ld_n,
    input  logic    cnt_inc_n,
    input  logic    cnt_rd_n,
    input  logic    msk_ld_n,
    input  logic    msk_rd_n,
    output cnt_op_e op,
    output logic    cnt_rd_ok,
    output logic    msk_rd_ok,
    output logic    msk_wr_ok
);
    // clear beats load, load beats increment
    always_comb begin
        if (!cnt_rst_n)      op = OP_CLR;
        else if (!cnt_ld_n)  op = OP_LOAD;
        else if (!cnt_inc_n) op = OP_INC;
        else                 op = OP_HOLD;
    end

    assign cnt_rd_ok = !cnt_rd_n && cnt_ld_n && cnt_inc_n && cnt_rst_n;
    assign msk_rd_ok = !msk_rd_n && cnt_rd_n && msk_ld_n;
    assign msk_wr_ok = !msk_ld_n && cnt_ld_n;
endmodule

// File: rtl/bac_mask_reg.sv
module bac_mask_reg #(
    parameter int AW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_data,
    output logic [AW-1:0] mask_q
);
    localparam logic [AW-1:0] MASK_ALL = {AW{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     mask_q <= MASK_ALL;
        else if (wr_en) mask_q <= wr_data;
    end

    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_mask_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(wr_en) |-> mask_q == $past(wr_data));
    assert_mask_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !$past(wr_en) |-> $stable(mask_q));
endmodule

// File: rtl/bac_count_core.sv
module bac_count_core
    import bac_pkg::*;
#(
    parameter int AW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cnt_op_e       op,
    input  logic [AW-1:0] ld_val,
    input  logic [AW-1:0] mask,
    output logic [AW-1:0] cnt_q,
    output logic          term_irq
);
    localparam logic [AW-1:0] ZERO = '0;

    logic [AW-1:0] stepped;
    logic [AW-1:0] cnt_d;
    logic          irq_d;

    // masked field counts, fixed field is kept
    assign stepped = (cnt_q & ~mask) | ((cnt_q + 1'b1) & mask);

    always_comb begin
        cnt_d = cnt_q;
        irq_d = term_irq;
        unique case (op)
            OP_CLR: begin
                cnt_d = ZERO;
                irq_d = 1'b0;
            end
            OP_LOAD: begin
                cnt_d = ld_val;
                irq_d = 1'b0;
            end
            OP_INC: begin
                cnt_d = stepped;
                irq_d = ((stepped & mask) == mask);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= ZERO;
            term_irq <= 1'b0;
        end else begin
            cnt_q    <= cnt_d;
            term_irq <= irq_d;
        end
    end

    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(op) == OP_CLR |-> cnt_q == ZERO);
    assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(op) == OP_LOAD |-> cnt_q == $past(ld_val));
    assert_fixed_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(op) == OP_INC |-> (cnt_q & ~$past(mask)) == ($past(cnt_q) & ~$past(mask)));
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(op) == OP_HOLD |-> $stable(cnt_q) && $stable(term_irq));
    assert_irq_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        armed && ($past(op) == OP_LOAD || $past(op) == OP_CLR) |-> !term_irq);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import bac_pkg::*;
#(
    parameter int AW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_rst_n,
    input  logic          cnt_ld_n,
    input  logic          cnt_inc_n,
    input  logic          cnt_rd_n,
    input  logic          msk_ld_n,
    input  logic          msk_rd_n,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] eff_addr,
    output logic [AW-1:0] rd_data,
    output logic          rd_oe,
    output logic          term_irq
);
    localparam logic [AW-1:0] ZERO = '0;

    cnt_op_e       op;
    logic          cnt_rd_ok;
    logic          msk_rd_ok;
    logic          msk_wr_ok;
    logic [AW-1:0] mask_q;
    logic [AW-1:0] cnt_q;

    bac_cmd_decode u_dec (
        .cnt_rst_n (cnt_rst_n),
        .cnt_ld_n  (cnt_ld_n),
        .cnt_inc_n (cnt_inc_n),
        .cnt_rd_n  (cnt_rd_n),
        .msk_ld_n  (msk_ld_n),
        .msk_rd_n  (msk_rd_n),
        .op        (op),
        .cnt_rd_ok (cnt_rd_ok),
        .msk_rd_ok (msk_rd_ok),
        .msk_wr_ok (msk_wr_ok)
    );

    bac_mask_reg #(.AW(AW)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (msk_wr_ok),
        .wr_data (addr_in),
        .mask_q  (mask_q)
    );

    bac_count_core #(.AW(AW)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .ld_val   (addr_in),
        .mask     (mask_q),
        .cnt_q    (cnt_q),
        .term_irq (term_irq)
    );

    // readback state machine
    rb_state_e     rb_state, rb_next;
    logic [AW-1:0] rb_val;

    always_comb begin
        if (cnt_rd_ok)      rb_next = RB_COUNT;
        else if (msk_rd_ok) rb_next = RB_MASK;
        else                rb_next = RB_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rb_state <= RB_IDLE;
            rb_val   <= ZERO;
        end else begin
            rb_state <= rb_next;
            unique case (rb_next)
                RB_COUNT: rb_val <= cnt_q;
                RB_MASK:  rb_val <= mask_q;
                default:  rb_val <= ZERO;
            endcase
        end
    end

    always_comb begin
        unique case (rb_state)
            RB_COUNT, RB_MASK: begin
                rd_oe   = 1'b1;
                rd_data = rb_val;
            end
            default: begin
                rd_oe   = 1'b0;
                rd_data = ZERO;
            end
        endcase
    end

    always_comb begin
        unique case (op)
            OP_CLR:  eff_addr = ZERO;
            OP_INC:  eff_addr = cnt_q;
            default: eff_addr = addr_in;
        endcase
    end

    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_cnt_readback_R9: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(!cnt_rd_n && cnt_ld_n && cnt_inc_n && cnt_rst_n)
        |-> rd_oe && rd_data == $past(cnt_q));
    assert_bad_readback_R9: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(!(cnt_ld_n && cnt_inc_n && cnt_rst_n)) && $past(msk_rd_n) |-> !rd_oe);
    assert_mask_readback_R10: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(!msk_rd_n && cnt_rd_n && msk_ld_n) |-> rd_oe && rd_data == $past(mask_q));
    assert_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rst_n && cnt_ld_n && cnt_inc_n |-> eff_addr == addr_in);
endmodule

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
    localparam int AW = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cnt_rst_n = 1'b1, cnt_ld_n = 1'b1, cnt_inc_n = 1'b1;
    logic          cnt_rd_n = 1'b1, msk_ld_n = 1'b1, msk_rd_n = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] eff_addr, rd_data;
    logic          rd_oe, term_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    burst_addr_gen #(.AW(AW)) u_burst_addr_gen (
        .clk(clk), .rst_n(rst_n), .cnt_rst_n(cnt_rst_n), .cnt_ld_n(cnt_ld_n),
        .cnt_inc_n(cnt_inc_n), .cnt_rd_n(cnt_rd_n), .msk_ld_n(msk_ld_n),
        .msk_rd_n(msk_rd_n), .addr_in(addr_in), .eff_addr(eff_addr),
        .rd_data(rd_data), .rd_oe(rd_oe), .term_irq(term_irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 rd_oe in reset", rd_oe, 0);
        rst_n = 1'b1;
        tick();
        chk("R1 rd_oe", rd_oe, 0);
        chk("R1 irq", term_irq, 0);
        cnt_rd_n = 1'b0; tick(); cnt_rd_n = 1'b1;
        chk("R1 counter zero oe", rd_oe, 1);
        chk("R1 counter zero", rd_data, 0);
        msk_rd_n = 1'b0; tick(); msk_rd_n = 1'b1;
        chk("R1 mask all ones", rd_data, 32'h7FFF);
    endtask

    task automatic t_pass();
        addr_in = 15'h1234; #1;
        chk("R2 passthru a", eff_addr, 32'h1234);
        addr_in = 15'h0ABC; #1;
        chk("R2 passthru b", eff_addr, 32'h0ABC);
    endtask

    task automatic t_load_inc();
        cnt_ld_n = 1'b0; addr_in = 15'h0100; #1;
        chk("R3 load same cycle", eff_addr, 32'h0100);
        tick();
        cnt_ld_n = 1'b1; cnt_inc_n = 1'b0; addr_in = 15'h0055; #1;
        chk("R3 loaded value", eff_addr, 32'h0100);
        tick(); #1;
        chk("R4 step 1", eff_addr, 32'h0101);
        tick(); #1;
        chk("R4 step 2", eff_addr, 32'h0102);
        cnt_inc_n = 1'b1; #1;
        chk("R2 after burst", eff_addr, 32'h0055);
        cnt_rd_n = 1'b0; tick(); cnt_rd_n = 1'b1;
        chk("R9 readback oe", rd_oe, 1);
        chk("R9 readback value", rd_data, 32'h0102);
        cnt_rd_n = 1'b0; cnt_inc_n = 1'b0; tick(); cnt_rd_n = 1'b1;
        chk("R9 illegal readback ignored", rd_oe, 0);
        #1;
        chk("R4 step during bad read", eff_addr, 32'h0103);
        cnt_inc_n = 1'b1;
    endtask

    task automatic t_clear();
        cnt_rst_n = 1'b0; cnt_ld_n = 1'b0; addr_in = 15'h0333; #1;
        chk("R5 zero same cycle", eff_addr, 0);
        tick();
        cnt_rst_n = 1'b1; cnt_ld_n = 1'b1; cnt_inc_n = 1'b0; #1;
        chk("R5 counter cleared over load", eff_addr, 0);
        cnt_inc_n = 1'b1;
    endtask

    task automatic t_prio();
        cnt_ld_n = 1'b0; cnt_inc_n = 1'b0; addr_in = 15'h0040; #1;
        chk("R6 load shown", eff_addr, 32'h0040);
        tick();
        cnt_ld_n = 1'b1; #1;
        chk("R6 load wins no step", eff_addr, 32'h0040);
        cnt_inc_n = 1'b1;
    endtask

    task automatic t_mask();
        msk_ld_n = 1'b0; addr_in = 15'h0003; tick(); msk_ld_n = 1'b1;
        msk_rd_n = 1'b0; tick(); msk_rd_n = 1'b1;
        chk("R10 mask readback oe", rd_oe, 1);
        chk("R8 mask written", rd_data, 32'h0003);
        cnt_ld_n = 1'b0; addr_in = 15'h1232; tick(); cnt_ld_n = 1'b1;
        chk("R11 irq low after load", term_irq, 0);
        cnt_inc_n = 1'b0; #1;
        chk("R7 start", eff_addr, 32'h1232);
        tick(); #1;
        chk("R7 step to terminal", eff_addr, 32'h1233);
        chk("R11 irq set", term_irq, 1);
        tick(); #1;
        chk("R7 masked wrap", eff_addr, 32'h1230);
        chk("R11 irq cleared by step", term_irq, 0);
        tick(); #1;
        chk("R7 after wrap", eff_addr, 32'h1231);
        cnt_inc_n = 1'b1;
        msk_ld_n = 1'b0; cnt_ld_n = 1'b0; addr_in = 15'h00F0; tick();
        msk_ld_n = 1'b1; cnt_ld_n = 1'b1;
        msk_rd_n = 1'b0; tick(); msk_rd_n = 1'b1;
        chk("R8 write ignored with load", rd_data, 32'h0003);
        cnt_inc_n = 1'b0; tick(); tick(); tick(); cnt_inc_n = 1'b1;
        chk("R11 irq at F3", term_irq, 1);
        tick();
        chk("R11 irq held", term_irq, 1);
        cnt_ld_n = 1'b0; addr_in = 15'h0010; tick(); cnt_ld_n = 1'b1;
        chk("R11 irq cleared by load", term_irq, 0);
    endtask

    task automatic t_full();
        msk_ld_n = 1'b0; addr_in = 15'h7FFF; tick(); msk_ld_n = 1'b1;
        cnt_ld_n = 1'b0; addr_in = 15'h7FFE; tick(); cnt_ld_n = 1'b1;
        cnt_inc_n = 1'b0; tick(); #1;
        chk("R7 full top", eff_addr, 32'h7FFF);
        chk("R11 irq full range", term_irq, 1);
        tick(); #1;
        chk("R7 full wrap", eff_addr, 0);
        chk("R11 irq clear full", term_irq, 0);
        cnt_inc_n = 1'b1;
    endtask

    bit done = 1'b0;

    initial begin
        t_reset();
        t_pass();
        t_load_inc();
        t_clear();
        t_prio();
        t_mask();
        t_full();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule